// File: doc/BRIEF.md
# Reset Pin Qualifier and Watchdog Reset Stretcher

This block produces the internal reset of a microcontroller core whose machine cycle lasts twelve oscillator clocks. It watches an active-high, bidirectional reset pin. A short glitch on the pin does nothing. The internal reset goes high only after the pin has been seen high on two full machine cycles' worth of consecutive clock samples. The pin is asynchronous to the core clock, so it passes through a small synchronizer before it is counted.

The block also turns a watchdog timeout into a reset of fixed length. A one-clock timeout pulse forces the internal reset high for a fixed number of oscillator clocks. During that same interval the block asks the pad to drive the reset pin high, so that other devices on the board are reset too. An auxiliary-register bit can suppress this outward drive. It does not shorten the internal reset.

An active-low power-on clear puts every counter in a known state, and the internal reset is held high while it is low. Every control pin is a plain level. There is no data stream.

Top module: `reset_pin_ctrl`

## Requirements
- R1: While `por_n` is low, `rst_core` is 1, `pin_oe` is 0 and `pin_drive_val` is 0. All counters are cleared, asynchronously.
- R2: `pin_level` passes through SYNC_STAGES (default 2) flops. `rst_core` rises right after the rising edge at which the synchronized pin has been high for CLKS_PER_MC*QUAL_MC (default 12*2 = 24) consecutive samples. A pin held high across exactly 24 rising edges asserts the reset.
- R3: Any single low sample restarts the count. A high run of 23 edges, or two 23-edge runs separated by one low edge, never asserts `rst_core`.
- R4: A `wdt_expire` pulse sampled at a rising edge holds `rst_core` high for exactly PULSE_CLKS (default 96) clock cycles, starting after that edge. This holds whatever the value of `rto_disable`.
- R5: While `rto_disable` is 0, `pin_oe` is high for exactly those PULSE_CLKS cycles. `pin_drive_val` is 1 whenever `pin_oe` is 1, so the pin is only ever driven high.
- R6: `rto_disable` = 1 forces `pin_oe` to 0 in the same cycle, combinationally. It leaves `rst_core` unchanged.
- R7: Release happens when the reset-out interval is over and the pin is low. `rst_core` falls after the (SYNC_STAGES+1)th rising edge at which the pin is low. If the pin is already low, it falls in the first cycle after the interval ends.
- R8: A `wdt_expire` pulse arriving during an active interval restarts it, giving a full PULSE_CLKS cycles counted from the new pulse.
- R9: If the pin is still high when the reset-out interval ends, `rst_core` stays high until the pin goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por_n | input | 1 | Asynchronous active-low power-on clear |
| pin_level | input | 1 | Level read back from the reset pad (asynchronous) |
| wdt_expire | input | 1 | One-clock watchdog timeout pulse |
| rto_disable | input | 1 | Auxiliary-register bit that suppresses the outward pin drive |
| rst_core | output | 1 | Internal core reset, active high |
| pin_oe | output | 1 | Output enable for the reset pad |
| pin_drive_val | output | 1 | Value for the pad to drive while enabled |

## Verification
The qualifier is driven with high runs of 1, 12, 23, 24 and 40 edges, and with split runs of 23+23 and 23+24 that have a one-edge low gap. These patterns locate the exact 24-sample threshold and show that a single low sample really restarts the count instead of pausing it. The stretcher is tried with `rto_disable` clear, with it set, with it toggled partway through an interval, with a second timeout mid-interval, and with the pin held high past the interval's end. Between them these runs separate the internal-reset length from the pad-drive length, restart from pause, and pulse-driven release from pin-driven release.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
  localparam int DEF_CLKS_PER_MC = 12;
  localparam int DEF_QUAL_MC     = 2;
  localparam int DEF_PULSE_CLKS  = 96;
  localparam int DEF_SYNC_STAGES = 2;

  typedef struct packed {
    logic qualified;
    logic stretching;
  } rst_cause_t;
endpackage

// File: rtl/rstc_sync.sv
module rstc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic d,
  output logic q
);
  generate
    if (STAGES <= 1) begin : g_single
      logic s_q;
      always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) s_q <= 1'b0;
        else        s_q <= d;
      end
      assign q = s_q;
    end else begin : g_chain
      logic [STAGES-1:0] sh_q;
      always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-2:0], d};
      end
      assign q = sh_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/rstc_qual.sv
module rstc_qual #(
  parameter int WINDOW = 24
) (
  input  logic clk,
  input  logic por_n,
  input  logic lvl,
  output logic qualified
);
  localparam int CW = $clog2(WINDOW + 1);
  localparam logic [CW-1:0] WIN_C = CW'(WINDOW);

  logic [CW-1:0] run_q;

  // Consecutive-high counter: saturates at WINDOW, cleared by any low sample.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)              run_q <= '0;
    else if (!lvl)           run_q <= '0;
    else if (run_q != WIN_C) run_q <= run_q + 1'b1;
  end

  assign qualified = (run_q == WIN_C);
endmodule

// File: rtl/rstc_stretch.sv
module rstc_stretch #(
  parameter int PULSE = 96
) (
  input  logic clk,
  input  logic por_n,
  input  logic trig,
  output logic active
);
  localparam int PW = $clog2(PULSE + 1);
  localparam logic [PW-1:0] PULSE_C = PW'(PULSE);

  logic [PW-1:0] left_q;

  // Loads on every trigger (restart), then counts down to zero.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)            left_q <= '0;
    else if (trig)         left_q <= PULSE_C;
    else if (left_q != '0) left_q <= left_q - 1'b1;
  end

  assign active = (left_q != '0);
endmodule

// File: rtl/reset_pin_ctrl.sv
module reset_pin_ctrl
  import rstc_pkg::*;
#(
  parameter int CLKS_PER_MC = DEF_CLKS_PER_MC,
  parameter int QUAL_MC     = DEF_QUAL_MC,
  parameter int PULSE_CLKS  = DEF_PULSE_CLKS,
  parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic clk,
  input  logic por_n,
  input  logic pin_level,
  input  logic wdt_expire,
  input  logic rto_disable,
  output logic rst_core,
  output logic pin_oe,
  output logic pin_drive_val
);
  localparam int WINDOW = CLKS_PER_MC * QUAL_MC;

  logic       pin_sync;
  rst_cause_t cause;

  rstc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .por_n (por_n),
    .d     (pin_level),
    .q     (pin_sync)
  );

  rstc_qual #(.WINDOW(WINDOW)) u_qual (
    .clk       (clk),
    .por_n     (por_n),
    .lvl       (pin_sync),
    .qualified (cause.qualified)
  );

  rstc_stretch #(.PULSE(PULSE_CLKS)) u_stretch (
    .clk    (clk),
    .por_n  (por_n),
    .trig   (wdt_expire),
    .active (cause.stretching)
  );

  assign rst_core      = !por_n || cause.qualified || cause.stretching;
  assign pin_oe        = cause.stretching && !rto_disable;
  assign pin_drive_val = cause.stretching;
endmodule

// File: rtl/reset_pin_ctrl_chk.sv
module reset_pin_ctrl_chk #(
  parameter int PULSE_CLKS = 96
) (
  input logic clk,
  input logic por_n,
  input logic wdt_expire,
  input logic rto_disable,
  input logic rst_core,
  input logic pin_oe,
  input logic pin_drive_val
);
  localparam int SW = $clog2(PULSE_CLKS + 1);
  localparam logic [SW-1:0] SAT = SW'(PULSE_CLKS);

  // Cycles since the latest timeout pulse, saturating at PULSE_CLKS.
  logic [SW-1:0] since_q;
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)            since_q <= SAT;
    else if (wdt_expire)   since_q <= '0;
    else if (since_q != SAT) since_q <= since_q + 1'b1;
  end

  always_comb begin
    if (por_n == 1'b0) begin
      p_por_state_r1: assert (rst_core && !pin_oe && !pin_drive_val);
    end
  end

  p_window_holds_reset_r4: assert property (@(posedge clk) disable iff (!por_n)
    (since_q != SAT) |-> rst_core);

  p_window_drives_pin_r5: assert property (@(posedge clk) disable iff (!por_n)
    ((since_q != SAT) && !rto_disable) |-> pin_oe);

  p_drive_is_high_r5: assert property (@(posedge clk) disable iff (!por_n)
    pin_oe |-> pin_drive_val);

  p_disable_blocks_drive_r6: assert property (@(posedge clk) disable iff (!por_n)
    rto_disable |-> !pin_oe);

  p_timeout_restarts_r8: assert property (@(posedge clk) disable iff (!por_n)
    wdt_expire |=> (rst_core && pin_drive_val));

  p_no_drive_after_window_r4: assert property (@(posedge clk) disable iff (!por_n)
    (since_q == SAT) |-> !pin_drive_val);
endmodule

bind reset_pin_ctrl reset_pin_ctrl_chk #(.PULSE_CLKS(PULSE_CLKS)) u_chk (
  .clk           (clk),
  .por_n         (por_n),
  .wdt_expire    (wdt_expire),
  .rto_disable   (rto_disable),
  .rst_core      (rst_core),
  .pin_oe        (pin_oe),
  .pin_drive_val (pin_drive_val)
);

// File: tb/sim_reset_pin_ctrl.sv
`timescale 1ns/1ps
module sim_reset_pin_ctrl;
  localparam int PULSE = 96;
  localparam int SYNC  = 2;
  localparam int NVEC  = 8;
  // {expect_reset, run1, gap, run2}
  localparam logic [24:0] VECS [0:NVEC-1] = '{
    {1'b0, 8'd1,  8'd0, 8'd0},
    {1'b0, 8'd12, 8'd0, 8'd0},
    {1'b0, 8'd23, 8'd0, 8'd0},
    {1'b1, 8'd24, 8'd0, 8'd0},
    {1'b1, 8'd40, 8'd0, 8'd0},
    {1'b0, 8'd23, 8'd1, 8'd23},
    {1'b1, 8'd23, 8'd1, 8'd24},
    {1'b0, 8'd20, 8'd3, 8'd20}
  };

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic pin_level = 1'b0;
  logic wdt_expire = 1'b0;
  logic rto_disable = 1'b0;
  logic rst_core, pin_oe, pin_drive_val;

  int n_cmp = 0;
  int n_bad = 0;
  logic mon = 1'b0;
  logic seen = 1'b0;

  always #10 clk = ~clk;

  reset_pin_ctrl u0 (
    .clk(clk), .por_n(por_n), .pin_level(pin_level), .wdt_expire(wdt_expire),
    .rto_disable(rto_disable), .rst_core(rst_core), .pin_oe(pin_oe),
    .pin_drive_val(pin_drive_val)
  );

  always @(negedge clk) if (mon && rst_core) seen <= 1'b1;

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic pulse_wdt();
    @(negedge clk) wdt_expire = 1'b1;
    @(negedge clk) wdt_expire = 1'b0;
  endtask

  initial begin
    #3_000_000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int cnt_r, cnt_o;
    // R1: power-on state
    repeat (3) @(negedge clk);
    chk("R1 rst_core in por", int'(rst_core), 1);
    chk("R1 pin_oe in por", int'(pin_oe), 0);
    chk("R1 drive_val in por", int'(pin_drive_val), 0);
    por_n = 1'b1;
    @(negedge clk);
    chk("R1 rst_core after por", int'(rst_core), 0);

    // R2/R3: qualification patterns
    for (int v = 0; v < NVEC; v++) begin
      repeat (5) @(negedge clk);
      seen = 1'b0;
      mon = 1'b1;
      pin_level = 1'b1;
      repeat (int'(VECS[v][23:16])) @(negedge clk);
      pin_level = 1'b0;
      repeat (int'(VECS[v][15:8])) @(negedge clk);
      if (VECS[v][7:0] != 8'd0) begin
        pin_level = 1'b1;
        repeat (int'(VECS[v][7:0])) @(negedge clk);
        pin_level = 1'b0;
      end
      repeat (6) @(negedge clk);
      mon = 1'b0;
      chk(VECS[v][24] ? "R2 qualify vector" : "R3 reject vector",
          int'(seen), int'(VECS[v][24]));
      chk("R7 released after vector", int'(rst_core), 0);
    end

    // R4/R5: pulse length with drive enabled
    rto_disable = 1'b0;
    pulse_wdt();
    cnt_r = 0; cnt_o = 0;
    for (int i = 0; i < 200 && rst_core; i++) begin
      cnt_r++;
      if (pin_oe && pin_drive_val) cnt_o++;
      @(negedge clk);
    end
    chk("R4 reset length", cnt_r, PULSE);
    chk("R5 drive length", cnt_o, PULSE);
    chk("R7 released at interval end", int'(rst_core), 0);

    // R4/R6: drive suppressed, reset unchanged
    rto_disable = 1'b1;
    pulse_wdt();
    cnt_r = 0; cnt_o = 0;
    for (int i = 0; i < 200 && rst_core; i++) begin
      cnt_r++;
      if (pin_oe) cnt_o++;
      @(negedge clk);
    end
    chk("R4 reset length disabled", cnt_r, PULSE);
    chk("R6 no drive when disabled", cnt_o, 0);

    // R6: mid-interval toggle acts in the same cycle
    rto_disable = 1'b0;
    pulse_wdt();
    repeat (10) @(negedge clk);
    rto_disable = 1'b1; #1;
    chk("R6 oe drops same cycle", int'(pin_oe), 0);
    chk("R6 reset kept", int'(rst_core), 1);
    rto_disable = 1'b0; #1;
    chk("R5 oe back", int'(pin_oe), 1);
    repeat (100) @(negedge clk);

    // R8: retrigger
    pulse_wdt();
    repeat (50) @(negedge clk);
    pulse_wdt();
    cnt_r = 0;
    for (int i = 0; i < 200 && rst_core; i++) begin
      cnt_r++;
      @(negedge clk);
    end
    chk("R8 restart length", cnt_r, PULSE);

    // R9/R7: pin held high past the interval
    pin_level = 1'b1;
    pulse_wdt();
    repeat (PULSE + 20) @(negedge clk);
    chk("R9 held by pin", int'(rst_core), 1);
    chk("R5 drive ended", int'(pin_oe), 0);
    pin_level = 1'b0;
    cnt_r = 0;
    for (int i = 0; i < 50 && rst_core; i++) begin
      @(negedge clk);
      if (rst_core) cnt_r++;
    end
    chk("R7 release latency", cnt_r, SYNC);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule